// File: doc/BRIEF.md
# Paged Serial Flash Host Sequencer

This block is the host-side engine for a serial flash that keeps a page-sized SRAM buffer (two of them) in front of its main array. A client raises a request carrying an operation code, a 12-bit page number, a column (start byte), and a buffer select. The sequencer then runs the whole serial transaction by itself. It builds the command frame, shifts it out in SPI mode 0, and returns read bytes on a strobed byte stream. For operations that the flash finishes on its own, it then polls the status register until the device reports ready. Only after that does it acknowledge the request.

The four operations have these request codes on `req_op`:
- 0: read a page straight from the array.
- 1: copy an array page into a buffer.
- 2: program a buffer into a page with erase.
- 3: program a buffer into a page without erase.

The controller has five named states: IDLE, XFER, GAP, POLL and ACK. The transitions are:
- IDLE→XFER when a request is accepted.
- XFER→ACK when a read frame ends.
- XFER→GAP when a self-timed frame ends.
- GAP→POLL, which is always taken after the one-cycle chip-select high time.
- POLL→ACK when the device is ready or the poll budget is used up.
- POLL→GAP when the device is still busy.
- ACK→IDLE, which is always taken.

A set of per-sector counters tallies program operations. Each counter raises a sticky flag once a sector reaches the rewrite threshold.

Top module: `pflash_seq`

## Requirements
- R1: The first 8 bits of each request frame are the opcode:
  - 52h for read.
  - 53h or 55h for a load into buffer 0 or buffer 1 (`req_buf` = 0/1).
  - 83h or 86h for a program with erase from buffer 0 or buffer 1.
  - 88h or 89h for a program without erase from buffer 0 or buffer 1.
- R2: The 24 address bits after the opcode are sent MSB first. They are 2 zero bits, then the 12-bit page number, then 10 column bits. The column bits carry `req_col` for a read and are zero for the other operations.
- R3: A read frame has 32 zero dummy bits after the address, then RD_BYTES data bytes in one chip-select period. Each data byte is MSB first and appears on `rd_data` with a one-cycle `rd_valid` pulse while CS is low. Load and program frames are exactly 32 bits long.
- R4: SPI mode 0 is used. SCK is low whenever CS is high, MOSI never changes on a rising SCK edge, and MISO is captured on the rising edge.
- R5: After a load or a program frame, CS goes high for at least one cycle. The block then issues status frames: opcode D7h followed by 8 read bits. It repeats them, with CS high between frames, until bit 7 of the returned status byte is 1, and only then acknowledges. A read is acknowledged with no status frame.
- R6: If `poll_limit` consecutive status frames all return bit 7 = 0, polling stops and the acknowledge carries `err` = 1. A `poll_limit` of 0 behaves as 1. Otherwise `err` is 0, and `err` is only ever high together with `ack`.
- R7: `ack` is a one-cycle pulse that comes after CS has returned high at the end of the last frame, and after every read byte. A new request is taken only in IDLE.
- R8: Each program request (code 2 or 3) increments the counter of sector `req_page[11:8]`. `wear_flag[s]` rises once sector s has seen WEAR_LIMIT programs and then stays high. Loads and reads do not count.
- R9: After reset, CS is high, SCK is low, and `ack`, `err`, `rd_valid` and all wear flags are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present; held until ack |
| req_op | input | 2 | 0 read, 1 load, 2 program+erase, 3 program no erase |
| req_page | input | 12 | Page number |
| req_col | input | 10 | Start byte for a read |
| req_buf | input | 1 | Buffer select |
| poll_limit | input | 16 | Maximum number of status frames |
| ack | output | 1 | Request complete pulse |
| err | output | 1 | Poll timeout, valid with ack |
| rd_data | output | 8 | Read byte |
| rd_valid | output | 1 | Read byte strobe |
| wear_flag | output | 16 | Per-sector rewrite threshold reached |
| spi_sck | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
The bench sweeps every operation code against both buffer selects and four pages: 0, 1, a mixed pattern, and all ones. That separates opcode decoding by operation and by buffer, and exposes page bits that are dropped or misplaced. Reads use distinct columns and a position-dependent data pattern, which catches column placement, dummy-bit miscounts and byte misalignment. The device model answers zero, one or two busy statuses with the low seven status bits forced to 1, which shows whether the ready bit is taken from the right position. A longer busy run against a small poll budget exercises the timeout. Repeated programs into three sectors cross the wear threshold, while loads into the same sectors must leave the flags untouched.

// File: rtl/pflash_pkg.sv
package pflash_pkg;
    typedef enum logic [1:0] {
        OP_READ    = 2'd0,
        OP_LOAD    = 2'd1,
        OP_PROG_ER = 2'd2,
        OP_PROG_NE = 2'd3
    } op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_XFER,
        ST_GAP,
        ST_POLL,
        ST_ACK
    } state_e;

    localparam logic [7:0] OPC_READ  = 8'h52;
    localparam logic [7:0] OPC_LOAD0 = 8'h53;
    localparam logic [7:0] OPC_LOAD1 = 8'h55;
    localparam logic [7:0] OPC_PRE0  = 8'h83;
    localparam logic [7:0] OPC_PRE1  = 8'h86;
    localparam logic [7:0] OPC_PRN0  = 8'h88;
    localparam logic [7:0] OPC_PRN1  = 8'h89;
    localparam logic [7:0] OPC_STAT  = 8'hD7;

    localparam int ADDR_W     = 24;
    localparam int DUMMY_BITS = 32;
    localparam int FRAME_W    = 8 + ADDR_W + DUMMY_BITS;
endpackage

// File: rtl/pflash_frame.sv
module pflash_frame
    import pflash_pkg::*;
#(
    parameter int PAGE_W   = 12,
    parameter int COL_W    = 10,
    parameter int RD_BYTES = 528,
    parameter int CNT_W    = 16
) (
    input  op_e                op,
    input  logic [PAGE_W-1:0]  page,
    input  logic [COL_W-1:0]   col,
    input  logic               buf_sel,
    output logic [FRAME_W-1:0] tx,
    output logic [CNT_W-1:0]   nbits,
    output logic               self_timed
);
    localparam int RSV_W = ADDR_W - PAGE_W - COL_W;
    localparam logic [CNT_W-1:0] NB_READ = CNT_W'(FRAME_W + 8 * RD_BYTES);
    localparam logic [CNT_W-1:0] NB_CMD  = CNT_W'(8 + ADDR_W);

    logic [7:0]        opc;
    logic [ADDR_W-1:0] addr;

    always_comb begin
        unique case (op)
            OP_READ:    opc = OPC_READ;
            OP_LOAD:    opc = buf_sel ? OPC_LOAD1 : OPC_LOAD0;
            OP_PROG_ER: opc = buf_sel ? OPC_PRE1  : OPC_PRE0;
            OP_PROG_NE: opc = buf_sel ? OPC_PRN1  : OPC_PRN0;
            default:    opc = OPC_READ;
        endcase
        addr       = {{RSV_W{1'b0}}, page, (op == OP_READ) ? col : {COL_W{1'b0}}};
        tx         = {opc, addr, {DUMMY_BITS{1'b0}}};
        nbits      = (op == OP_READ) ? NB_READ : NB_CMD;
        self_timed = (op != OP_READ);
    end
endmodule

// File: rtl/pflash_shift.sv
module pflash_shift #(
    parameter int FRAME_W = 64,
    parameter int CNT_W   = 16
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [FRAME_W-1:0] tx,
    input  logic [CNT_W-1:0]   nbits,
    input  logic               miso,
    output logic               sck,
    output logic               mosi,
    output logic               done,
    output logic               byte_stb,
    output logic [7:0]         rx_byte
);
    logic [FRAME_W-1:0] txsr;
    logic [CNT_W-1:0]   cnt;
    logic               busy, ph;
    logic [2:0]         bitn;
    logic [7:0]         rxsr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txsr <= '0; cnt <= '0; busy <= 1'b0; ph <= 1'b0; bitn <= '0;
            rxsr <= '0; sck <= 1'b0; done <= 1'b0; byte_stb <= 1'b0; rx_byte <= '0;
        end else begin
            done     <= 1'b0;
            byte_stb <= 1'b0;
            if (start) begin
                txsr <= tx; cnt <= nbits; busy <= 1'b1;
                ph <= 1'b0; bitn <= '0; sck <= 1'b0;
            end else if (busy) begin
                if (!ph) begin
                    sck  <= 1'b1;
                    rxsr <= {rxsr[6:0], miso};
                    bitn <= bitn + 3'd1;
                    ph   <= 1'b1;
                end else begin
                    sck  <= 1'b0;
                    txsr <= {txsr[FRAME_W-2:0], 1'b0};
                    cnt  <= cnt - 1'b1;
                    ph   <= 1'b0;
                    if (bitn == 3'd0) begin
                        byte_stb <= 1'b1;
                        rx_byte  <= rxsr;
                    end
                    if (cnt == CNT_W'(1)) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end
                end
            end
        end
    end

    assign mosi = txsr[FRAME_W-1];
endmodule

// File: rtl/pflash_wear.sv
module pflash_wear #(
    parameter int SECT_W = 4,
    parameter int LIMIT  = 10000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    inc,
    input  logic [SECT_W-1:0]       sector,
    output logic [(1<<SECT_W)-1:0]  flag
);
    localparam int NSECT = 1 << SECT_W;
    localparam int CW    = $clog2(LIMIT + 1);

    for (genvar s = 0; s < NSECT; s++) begin : g_sect
        logic [CW-1:0] c;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                c <= '0;
            else if (inc && sector == SECT_W'(s) && c < CW'(LIMIT))
                c <= c + 1'b1;
        end
        assign flag[s] = (c >= CW'(LIMIT));
    end
endmodule

// File: rtl/pflash_seq.sv
module pflash_seq
    import pflash_pkg::*;
#(
    parameter int PAGE_W     = 12,
    parameter int COL_W      = 10,
    parameter int RD_BYTES   = 528,
    parameter int WEAR_LIMIT = 10000,
    parameter int POLL_W     = 16,
    parameter int SECT_LOG2  = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_valid,
    input  logic [1:0]                      req_op,
    input  logic [PAGE_W-1:0]               req_page,
    input  logic [COL_W-1:0]                req_col,
    input  logic                            req_buf,
    input  logic [POLL_W-1:0]               poll_limit,
    output logic                            ack,
    output logic                            err,
    output logic [7:0]                      rd_data,
    output logic                            rd_valid,
    output logic [(1<<(PAGE_W-SECT_LOG2))-1:0] wear_flag,
    output logic                            spi_sck,
    output logic                            spi_cs_n,
    output logic                            spi_mosi,
    input  logic                            spi_miso
);
    localparam int CNT_W     = 16;
    localparam int SECT_W    = PAGE_W - SECT_LOG2;
    localparam int HDR_BYTES = FRAME_W / 8;

    state_e state_q, state_d;
    op_e    op_in;

    logic [FRAME_W-1:0] fr_tx, sh_tx;
    logic [CNT_W-1:0]   fr_nbits, sh_nbits, byte_cnt;
    logic               fr_st, st_q, rd_q, err_q, cs_n_q;
    logic               sh_start, sh_done, sh_stb, accept, timeout;
    logic [7:0]         rx_byte;
    logic [POLL_W-1:0]  poll_q;

    assign op_in = op_e'(req_op);

    pflash_frame #(.PAGE_W(PAGE_W), .COL_W(COL_W), .RD_BYTES(RD_BYTES), .CNT_W(CNT_W)) u_frame (
        .op(op_in), .page(req_page), .col(req_col), .buf_sel(req_buf),
        .tx(fr_tx), .nbits(fr_nbits), .self_timed(fr_st)
    );

    pflash_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .start(sh_start), .tx(sh_tx), .nbits(sh_nbits),
        .miso(spi_miso), .sck(spi_sck), .mosi(spi_mosi), .done(sh_done),
        .byte_stb(sh_stb), .rx_byte(rx_byte)
    );

    pflash_wear #(.SECT_W(SECT_W), .LIMIT(WEAR_LIMIT)) u_wear (
        .clk(clk), .rst_n(rst_n),
        .inc(accept && (op_in == OP_PROG_ER || op_in == OP_PROG_NE)),
        .sector(req_page[PAGE_W-1 -: SECT_W]), .flag(wear_flag)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    assign timeout = ({1'b0, poll_q} + 1'b1) >= {1'b0, poll_limit};

    // next state and frame launch
    always_comb begin
        state_d  = state_q;
        sh_start = 1'b0;
        sh_tx    = fr_tx;
        sh_nbits = fr_nbits;
        accept   = 1'b0;
        unique case (state_q)
            ST_IDLE: if (req_valid) begin
                accept = 1'b1; sh_start = 1'b1; state_d = ST_XFER;
            end
            ST_XFER: if (sh_done) state_d = st_q ? ST_GAP : ST_ACK;
            ST_GAP: begin
                sh_start = 1'b1;
                sh_tx    = {OPC_STAT, {(FRAME_W-8){1'b0}}};
                sh_nbits = CNT_W'(16);
                state_d  = ST_POLL;
            end
            ST_POLL: if (sh_done) state_d = (rx_byte[7] || timeout) ? ST_ACK : ST_GAP;
            ST_ACK:  state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= 1'b0; rd_q <= 1'b0; err_q <= 1'b0; cs_n_q <= 1'b1;
            poll_q <= '0; byte_cnt <= '0;
        end else begin
            if (accept) begin
                st_q <= fr_st; rd_q <= (op_in == OP_READ);
                err_q <= 1'b0; poll_q <= '0; byte_cnt <= '0;
            end else if (sh_stb) begin
                byte_cnt <= byte_cnt + 1'b1;
            end
            if (sh_start)     cs_n_q <= 1'b0;
            else if (sh_done) cs_n_q <= 1'b1;
            if (state_q == ST_POLL && sh_done && !rx_byte[7]) begin
                poll_q <= poll_q + 1'b1;
                if (timeout) err_q <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        ack      = (state_q == ST_ACK);
        err      = ack && err_q;
        spi_cs_n = cs_n_q;
        rd_data  = rx_byte;
        rd_valid = sh_stb && rd_q && (state_q == ST_XFER) && (byte_cnt >= CNT_W'(HDR_BYTES));
    end
endmodule

// File: rtl/pflash_seq_chk.sv
module pflash_seq_chk #(
    parameter int NF = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          spi_sck,
    input logic          spi_cs_n,
    input logic          spi_mosi,
    input logic          ack,
    input logic          err,
    input logic          rd_valid,
    input logic [NF-1:0] wear_flag
);
    a_r4_sck_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        spi_cs_n |-> !spi_sck);

    a_r4_mosi_steady_at_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(spi_sck) |-> $stable(spi_mosi));

    a_r7_ack_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> !ack);

    a_r7_ack_after_cs_high: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> spi_cs_n);

    a_r6_err_with_ack: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> ack);

    a_r3_bytes_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> !spi_cs_n);

    a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(wear_flag) & ~wear_flag) == '0));
endmodule

bind pflash_seq pflash_seq_chk #(.NF($bits(wear_flag))) u_chk (
    .clk(clk), .rst_n(rst_n), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n),
    .spi_mosi(spi_mosi), .ack(ack), .err(err), .rd_valid(rd_valid),
    .wear_flag(wear_flag)
);

// File: tb/pflash_seq_tb.sv
module pflash_seq_tb;
    localparam int CLK_P = 10;
    localparam int RDB   = 4;
    localparam int WLIM  = 3;

    logic        clk = 0, rst_n = 0;
    logic        req_valid = 0, req_buf = 0;
    logic [1:0]  req_op = 0;
    logic [11:0] req_page = 0;
    logic [9:0]  req_col = 0;
    logic [15:0] poll_limit = 16'd8;
    logic        ack, err, rd_valid, spi_sck, spi_cs_n, spi_mosi;
    logic        spi_miso = 0;
    logic [7:0]  rd_data;
    logic [15:0] wear_flag;

    int n_tests = 0, n_fail = 0;

    always #(CLK_P/2) clk = ~clk;

    pflash_seq #(.RD_BYTES(RDB), .WEAR_LIMIT(WLIM)) u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_op(req_op),
        .req_page(req_page), .req_col(req_col), .req_buf(req_buf),
        .poll_limit(poll_limit), .ack(ack), .err(err), .rd_data(rd_data),
        .rd_valid(rd_valid), .wear_flag(wear_flag), .spi_sck(spi_sck),
        .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
    );

    function automatic logic [7:0] dexp(input logic [11:0] pg, input logic [9:0] cl, input int k);
        return pg[7:0] ^ cl[7:0] ^ (8'(k) * 8'd29 + 8'd5);
    endfunction

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // flash device model
    int          mb = 0, stat_frames = 0, busy_left = 0, last_bits = 0;
    logic [63:0] mcap = 0;
    logic [7:0]  mop = 0;
    logic [31:0] first32 = 0, last_cmd = 0;

    always @(negedge spi_cs_n) begin mb = 0; mcap = 0; mop = 0; end
    always @(posedge spi_sck) begin
        mcap = {mcap[62:0], spi_mosi};
        mb = mb + 1;
        if (mb == 8)  mop = mcap[7:0];
        if (mb == 32) first32 = mcap[31:0];
    end
    always @(negedge spi_sck) begin
        if (mop == 8'hD7 && mb >= 8 && mb < 16)
            spi_miso <= (mb == 8) ? (busy_left == 0) : 1'b1;
        else if (mop == 8'h52 && mb >= 64)
            spi_miso <= dexp(first32[21:10], first32[9:0], (mb-64)/8)[7-((mb-64)%8)];
        else
            spi_miso <= 1'b0;
    end
    always @(posedge spi_cs_n) begin
        if (mop == 8'hD7) begin
            stat_frames++;
            if (busy_left > 0) busy_left--;
        end else if (mb > 0) begin
            last_cmd = first32; last_bits = mb;
        end
    end

    // read byte collector and SPI mode monitor
    logic [7:0] rbuf [16];
    int rcnt = 0, mode_bad = 0;
    logic psck = 0, pmosi = 0;
    always @(negedge clk) begin
        if (rd_valid && rcnt < 16) begin rbuf[rcnt] = rd_data; rcnt++; end
        if (spi_sck && !psck && spi_mosi !== pmosi) mode_bad++;
        if (spi_cs_n && spi_sck) mode_bad++;
        psck = spi_sck; pmosi = spi_mosi;
    end

    int wexp [16];
    logic got_err;
    int ack_w;

    task automatic do_req(input int op, input logic [11:0] pg, input logic [9:0] cl,
                          input bit bsel, input int busy);
        busy_left = busy; stat_frames = 0; rcnt = 0;
        @(negedge clk);
        req_valid = 1; req_op = 2'(op); req_page = pg; req_col = cl; req_buf = bsel;
        while (!ack) @(negedge clk);
        got_err = err;
        req_valid = 0;
        @(negedge clk);
        ack_w = ack ? 2 : 1;
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++;
        $display("FAIL R7 watchdog actual=0 expected=1");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] opc;
        logic [11:0] pages [4];
        pages[0] = 12'h000; pages[1] = 12'h001; pages[2] = 12'hABC; pages[3] = 12'hFFF;
        for (int s = 0; s < 16; s++) wexp[s] = 0;
        repeat (3) @(negedge clk);
        chk(spi_cs_n == 1 && spi_sck == 0 && ack == 0 && err == 0 && rd_valid == 0,
            "R9 reset outputs", {spi_cs_n, spi_sck, ack, err, rd_valid}, 5'b10000);
        chk(wear_flag == 0, "R9 reset wear flags", wear_flag, 0);
        rst_n = 1;
        repeat (2) @(negedge clk);

        for (int op = 0; op < 4; op++) begin
            for (int b = 0; b < 2; b++) begin
                for (int pi = 0; pi < 4; pi++) begin
                    logic [11:0] pg;
                    logic [9:0] cl;
                    int busy;
                    pg = pages[pi];
                    cl = 10'(pi * 131 + b * 7 + 3);
                    busy = (pi + b) % 3;
                    do_req(op, pg, cl, b[0], busy);
                    case (op)
                        0: opc = 8'h52;
                        1: opc = b ? 8'h55 : 8'h53;
                        2: opc = b ? 8'h86 : 8'h83;
                        default: opc = b ? 8'h89 : 8'h88;
                    endcase
                    chk(last_cmd[31:24] == opc, "R1 opcode", last_cmd[31:24], opc);
                    chk(last_cmd[23:0] == {2'b00, pg, (op == 0) ? cl : 10'd0},
                        "R2 address", last_cmd[23:0], {2'b00, pg, (op == 0) ? cl : 10'd0});
                    chk(ack_w == 1, "R7 ack width", ack_w, 1);
                    chk(got_err == 0, "R6 no error", got_err, 0);
                    if (op == 0) begin
                        chk(last_bits == 64 + 8 * RDB, "R3 read frame bits", last_bits, 64 + 8 * RDB);
                        chk(rcnt == RDB, "R3 byte count", rcnt, RDB);
                        for (int k = 0; k < RDB; k++)
                            chk(rbuf[k] == dexp(pg, cl, k), "R3 read data", rbuf[k], dexp(pg, cl, k));
                        chk(stat_frames == 0, "R5 no poll on read", stat_frames, 0);
                    end else begin
                        chk(last_bits == 32, "R3 command frame bits", last_bits, 32);
                        chk(stat_frames == busy + 1, "R5 poll count", stat_frames, busy + 1);
                        chk(rcnt == 0, "R3 no bytes outside read", rcnt, 0);
                    end
                    if (op >= 2) wexp[pg[11:8]]++;
                    for (int s = 0; s < 16; s++)
                        chk(wear_flag[s] == (wexp[s] >= WLIM), "R8 wear flag", wear_flag[s], wexp[s] >= WLIM);
                end
            end
        end

        // poll timeout
        poll_limit = 16'd3;
        do_req(1, 12'h123, 10'd0, 1'b0, 10);
        chk(got_err == 1, "R6 timeout error", got_err, 1);
        chk(stat_frames == 3, "R6 polls before timeout", stat_frames, 3);
        poll_limit = 16'd0;
        do_req(2, 12'h234, 10'd0, 1'b1, 5);
        chk(got_err == 1 && stat_frames == 1, "R6 zero limit acts as one", stat_frames, 1);
        wexp[2]++;
        poll_limit = 16'd8;
        do_req(3, 12'h345, 10'd0, 1'b0, 2);
        chk(got_err == 0 && stat_frames == 3, "R5 ready after busy", stat_frames, 3);
        wexp[3]++;
        for (int s = 0; s < 16; s++)
            chk(wear_flag[s] == (wexp[s] >= WLIM), "R8 wear flag final", wear_flag[s], wexp[s] >= WLIM);
        chk(mode_bad == 0, "R4 SPI mode 0 timing", mode_bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule